// File: doc/BRIEF.md
# Free-Running Two-Channel ADC Result Interface

This block is the digital side of an on-chip analog-to-digital converter that keeps converting once it has been started. A channel-select command names one of the analog inputs and starts the converter on it. The converter then keeps converting that input with no further command. It counts instruction-cycle enable pulses, and every fourth pulse completes a conversion. The analog front end is not modelled. Each input instead appears as an 8-bit code on a packed sample bus, and the code of the selected channel is latched when a conversion completes.

The CPU reads the latest completed code with a one-cycle read strobe. The value returned comes with two flags. The valid flag says that at least one conversion has completed since the last select. The fresh flag says that this value has not been read before. A new select restarts the pulse count from zero and invalidates the held result until the first conversion on the new channel completes. When a read and a completion fall in the same cycle, the read returns the older value and the new one waits for the next read.

Top module: `freerun_adc`

## Requirements
- R1: After reset, rd_data is 0, rd_valid and rd_fresh are 0, conv_done is 0, conv_active is 0 and cur_chan is 0.
- R2: A cycle with sel_req high loads sel_chan into cur_chan and sets conv_active, both visible in the next cycle.
- R3: The first conversion after a select completes on the fourth icyc_en pulse counted in the cycles after the select cycle. conv_done is high for one cycle, in the cycle after the completing pulse.
- R4: Once started, conversions repeat on every fourth icyc_en pulse without a new select. Cycles with icyc_en low do not advance the count.
- R5: A completing conversion latches the code of the current channel, taken from samp_codes bits [8*k+7:8*k] for channel k in that cycle.
- R6: A select clears the valid and fresh flags and restarts the pulse count from zero. A select wins over an icyc_en pulse in the same cycle, and that pulse is not counted.
- R7: A cycle with rd_req high loads the held result and its valid and fresh flags onto rd_data, rd_valid and rd_fresh in the next cycle. Without rd_req those outputs hold their value.
- R8: A completion sets the fresh flag and a read clears it, so a second read of the same result reports rd_fresh = 0.
- R9: When rd_req and a completing pulse fall in the same cycle, the read returns the previous result with its previous flags. The new result is kept with fresh set for the next read.
- R10: Before the first select, icyc_en pulses start no conversion: conv_active stays 0 and the result stays 0 and invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icyc_en | input | 1 | One pulse per instruction cycle; advances the conversion count |
| sel_req | input | 1 | Channel-select command; starts or restarts conversion |
| sel_chan | input | 1 | Channel chosen by the select command |
| samp_codes | input | 16 | Packed per-channel sample codes, channel k at bits [8*k+7:8*k] |
| rd_req | input | 1 | Read strobe for the held result |
| rd_data | output | 8 | Result returned by the last read |
| rd_valid | output | 1 | Valid flag returned by the last read |
| rd_fresh | output | 1 | Fresh flag returned by the last read |
| conv_done | output | 1 | One-cycle pulse after each completed conversion |
| conv_active | output | 1 | Converter has been started by a select |
| cur_chan | output | 1 | Channel being converted |

## Verification
The directed part first sends enable pulses with no select, which shows that pulses alone start nothing. It then drives back-to-back pulses and reads after the third and after the fourth pulse, which pins the exact completion point. Pulses spaced one cycle apart show that idle cycles do not count. A select that arrives together with a pulse, and a read that arrives together with the completing pulse, separate the two same-cycle priority rules. Several thousand random cycles follow, with sparse selects, frequent reads and changing sample codes, compared each clock against a queue-free behavioural model.

// File: rtl/frad_pkg.sv
package frad_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic valid;
        logic fresh;
    } res_flags_t;

    localparam res_flags_t FLAGS_CLEAR = '{valid: 1'b0, fresh: 1'b0};
    localparam res_flags_t FLAGS_NEW   = '{valid: 1'b1, fresh: 1'b1};

    function automatic logic last_pulse(input int unsigned cnt, input int unsigned lim);
        return cnt == (lim - 1);
    endfunction

    function automatic int unsigned cnt_width(input int unsigned lim);
        return (lim > 1) ? $clog2(lim) : 1;
    endfunction

endpackage

// File: rtl/frad_chan_sel.sv
module frad_chan_sel #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sel_req,
    input  logic [CH_W-1:0]          sel_chan,
    input  logic [NUM_CH*DATA_W-1:0] samp_codes,
    output logic [CH_W-1:0]          cur_chan,
    output logic [DATA_W-1:0]        samp_cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_chan <= '0;
        end else if (sel_req) begin
            cur_chan <= sel_chan;
        end
    end

    always_comb begin
        samp_cur = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (cur_chan == CH_W'(k)) begin
                samp_cur = samp_codes[k*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/frad_conv_seq.sv
module frad_conv_seq
    import frad_pkg::*;
#(
    parameter int CYC_PER_CONV = 4,
    localparam int CNT_W       = cnt_width(CYC_PER_CONV)
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_req,
    input  logic icyc_en,
    output logic active,
    output logic conv_fire
);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end    = last_pulse(32'(cnt_q), CYC_PER_CONV);
    assign active    = (state_q == SEQ_RUN);
    assign conv_fire = active && icyc_en && !sel_req && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (sel_req) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
        end else if (active && icyc_en) begin
            cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/frad_result_port.sv
module frad_result_port
    import frad_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_req,
    input  logic              conv_fire,
    input  logic [DATA_W-1:0] samp_cur,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_fresh,
    output logic              conv_done
);

    logic [DATA_W-1:0] result_q;
    res_flags_t        flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q  <= '0;
            flags_q   <= FLAGS_CLEAR;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            rd_fresh  <= 1'b0;
            conv_done <= 1'b0;
        end else begin
            conv_done <= conv_fire;
            if (rd_req) begin
                rd_data  <= result_q;
                rd_valid <= flags_q.valid;
                rd_fresh <= flags_q.fresh;
            end
            if (conv_fire) begin
                result_q <= samp_cur;
                flags_q  <= FLAGS_NEW;
            end else if (sel_req) begin
                flags_q  <= FLAGS_CLEAR;
            end else if (rd_req) begin
                flags_q.fresh <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/freerun_adc.sv
module freerun_adc #(
    parameter int NUM_CH       = 2,
    parameter int DATA_W       = 8,
    parameter int CYC_PER_CONV = 4,
    localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     icyc_en,
    input  logic                     sel_req,
    input  logic [CH_W-1:0]          sel_chan,
    input  logic [NUM_CH*DATA_W-1:0] samp_codes,
    input  logic                     rd_req,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid,
    output logic                     rd_fresh,
    output logic                     conv_done,
    output logic                     conv_active,
    output logic [CH_W-1:0]          cur_chan
);

    logic [DATA_W-1:0] samp_cur;
    logic              conv_fire;

    frad_chan_sel #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chan (
        .clk        (clk),
        .rst        (rst),
        .sel_req    (sel_req),
        .sel_chan   (sel_chan),
        .samp_codes (samp_codes),
        .cur_chan   (cur_chan),
        .samp_cur   (samp_cur)
    );

    frad_conv_seq #(.CYC_PER_CONV(CYC_PER_CONV)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sel_req   (sel_req),
        .icyc_en   (icyc_en),
        .active    (conv_active),
        .conv_fire (conv_fire)
    );

    frad_result_port #(.DATA_W(DATA_W)) u_res (
        .clk       (clk),
        .rst       (rst),
        .sel_req   (sel_req),
        .conv_fire (conv_fire),
        .samp_cur  (samp_cur),
        .rd_req    (rd_req),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_fresh  (rd_fresh),
        .conv_done (conv_done)
    );

endmodule

// File: rtl/freerun_adc_chk.sv
module freerun_adc_chk #(
    parameter int NUM_CH       = 2,
    parameter int DATA_W       = 8,
    parameter int CYC_PER_CONV = 4,
    localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              icyc_en,
    input logic              sel_req,
    input logic [CH_W-1:0]   sel_chan,
    input logic              rd_req,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_fresh,
    input logic              conv_done,
    input logic              conv_active,
    input logic [CH_W-1:0]   cur_chan
);

    // Pulses seen since the last select or completion, counted from the ports.
    logic [7:0] pulses_q;

    always_ff @(posedge clk) begin
        if (rst || sel_req) begin
            pulses_q <= '0;
        end else if (conv_active && icyc_en) begin
            pulses_q <= conv_done ? 8'd1 : pulses_q + 8'd1;
        end else if (conv_done) begin
            pulses_q <= '0;
        end
    end

    assert_sel_latch_R2: assert property (@(posedge clk) disable iff (rst)
        sel_req |=> (cur_chan == $past(sel_chan)) && conv_active);

    assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (rst)
        pulses_q <= 8'(CYC_PER_CONV));

    assert_conv_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        conv_done |-> (pulses_q == 8'(CYC_PER_CONV)));

    assert_select_restart_R6: assert property (@(posedge clk) disable iff (rst)
        sel_req |=> !conv_done);

    assert_read_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(rd_data) && $stable(rd_valid) && $stable(rd_fresh));

    assert_fresh_from_read_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_fresh) |-> $past(rd_req));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !conv_active |-> !conv_done);

endmodule

bind freerun_adc freerun_adc_chk #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CYC_PER_CONV(CYC_PER_CONV)
) u_chk (
    .clk(clk), .rst(rst), .icyc_en(icyc_en), .sel_req(sel_req),
    .sel_chan(sel_chan), .rd_req(rd_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_fresh(rd_fresh), .conv_done(conv_done),
    .conv_active(conv_active), .cur_chan(cur_chan)
);

// File: tb/test_freerun_adc.sv
module test_freerun_adc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        icyc_en = 1'b0;
    logic        sel_req = 1'b0;
    logic        sel_chan = 1'b0;
    logic [15:0] samp_codes = '0;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid, rd_fresh, conv_done, conv_active, cur_chan;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    freerun_adc i_freerun_adc (
        .clk(clk), .rst(rst), .icyc_en(icyc_en), .sel_req(sel_req),
        .sel_chan(sel_chan), .samp_codes(samp_codes), .rd_req(rd_req),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_fresh(rd_fresh),
        .conv_done(conv_done), .conv_active(conv_active), .cur_chan(cur_chan)
    );

    // Behavioural reference, written from the requirements.
    int m_started, m_chan, m_pulses, m_result, m_valid, m_fresh;
    int m_rd_data, m_rd_valid, m_rd_fresh, m_done;

    always @(posedge clk) begin
        if (rst) begin
            m_started = 0; m_chan = 0; m_pulses = 0; m_result = 0;
            m_valid = 0; m_fresh = 0; m_rd_data = 0; m_rd_valid = 0;
            m_rd_fresh = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (rd_req) begin
                m_rd_data = m_result; m_rd_valid = m_valid; m_rd_fresh = m_fresh;
                m_fresh = 0;
            end
            if (sel_req) begin
                m_started = 1; m_chan = int'(sel_chan); m_pulses = 0;
                m_valid = 0; m_fresh = 0;
            end else if (m_started != 0 && icyc_en) begin
                m_pulses = m_pulses + 1;
                if (m_pulses == 4) begin
                    m_pulses = 0;
                    m_result = int'(m_chan == 0 ? samp_codes[7:0] : samp_codes[15:8]);
                    m_valid = 1; m_fresh = 1; m_done = 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R7 rd_data",     int'(rd_data),     m_rd_data);
            chk("R6 rd_valid",    int'(rd_valid),    m_rd_valid);
            chk("R8 rd_fresh",    int'(rd_fresh),    m_rd_fresh);
            chk("R3 conv_done",   int'(conv_done),   m_done);
            chk("R10 conv_active", int'(conv_active), m_started);
            chk("R2 cur_chan",    int'(cur_chan),    m_chan);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic step(input logic en, input logic s, input logic ch, input logic r);
        @(negedge clk);
        icyc_en = en; sel_req = s; sel_chan = ch; rd_req = r;
    endtask

    task automatic read_back();
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 rd_fresh", int'(rd_fresh), 0);
        chk("R1 conv_done", int'(conv_done), 0);
        chk("R1 conv_active", int'(conv_active), 0);
        chk("R1 cur_chan", int'(cur_chan), 0);

        samp_codes = {8'hA5, 8'h3C};
        // R10 pulses before any select
        repeat (6) step(1, 0, 0, 0);
        read_back();
        chk("R10 active", int'(conv_active), 0);
        chk("R10 valid", int'(rd_valid), 0);
        chk("R10 data", int'(rd_data), 0);

        // R3 completion exactly on the fourth pulse
        step(0, 1, 0, 0);
        repeat (3) step(1, 0, 0, 0);
        read_back();
        chk("R3 not yet valid", int'(rd_valid), 0);
        step(1, 0, 0, 0);
        read_back();
        chk("R5 ch0 code", int'(rd_data), 8'h3C);
        chk("R3 valid", int'(rd_valid), 1);
        chk("R8 fresh on first read", int'(rd_fresh), 1);
        read_back();
        chk("R8 fresh cleared", int'(rd_fresh), 0);
        chk("R8 data held", int'(rd_data), 8'h3C);

        // R4 spaced pulses, no new select
        samp_codes[7:0] = 8'h77;
        for (int i = 0; i < 8; i++) step((i % 2) == 0, 0, 0, 0);
        read_back();
        chk("R4 repeat conversion", int'(rd_data), 8'h77);
        chk("R4 fresh", int'(rd_fresh), 1);

        // R6 select with a pulse in the same cycle
        step(1, 1, 1, 0);
        read_back();
        chk("R6 invalid after select", int'(rd_valid), 0);
        chk("R2 channel", int'(cur_chan), 1);
        repeat (4) step(1, 0, 0, 0);
        read_back();
        chk("R5 ch1 code", int'(rd_data), 8'hA5);
        chk("R6 valid again", int'(rd_valid), 1);
        read_back();

        // R9 read collides with completion
        samp_codes[15:8] = 8'hC3;
        repeat (3) step(1, 0, 0, 0);
        step(1, 0, 0, 1);
        step(0, 0, 0, 0);
        chk("R9 old data", int'(rd_data), 8'hA5);
        chk("R9 old fresh", int'(rd_fresh), 0);
        chk("R3 done pulse", int'(conv_done), 1);
        read_back();
        chk("R9 new data", int'(rd_data), 8'hC3);
        chk("R9 new fresh", int'(rd_fresh), 1);

        // Random traffic compared against the reference every clock
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 1) == 1, $urandom_range(0, 39) == 0,
                 $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
            if ($urandom_range(0, 5) == 0) samp_codes = 16'($urandom);
        end
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule